// File: doc/BRIEF.md
# Data-Memory Address Generator

This block produces one data-memory address per clock from a single address pointer, with no help from the arithmetic datapath. A processor loads the pointer once. Each later access then takes one step strobe. The block presents the effective address for that access and moves the pointer in the same cycle, so a filter or transform inner loop spends no instructions on pointer arithmetic or bounds checks.

Five modes select how the pointer moves:
- Linear post-modify and linear pre-modify, each with a signed step.
- Circular addressing over a buffer given by an explicit start address and length.
- Circular addressing over a buffer whose start is taken as the pointer aligned down to the power of two that covers the length.
- Reverse-carry stepping, which walks radix-2 FFT data in bit-reversed order.

The circular wrap and the reverse-carry increment are done in hardware on every access.

Top module: `agu_top`

## Requirements
- R1: After reset `ptr` is 0, `ea_vld` is 0 and `step_err` is 0.
- R2: A cycle with `ld` high makes `ptr` equal to `ld_val` one clock later, with `ea_vld` low. `ld` wins over a simultaneous `stp`.
- R3: In post-modify mode (`mode` 0, and the unused codes 5 to 7), a `stp` cycle presents the old pointer on `ea` one clock later. `ptr` becomes the old pointer plus the sign-extended `step`, modulo 2^AW.
- R4: In pre-modify mode (`mode` 1), a `stp` cycle makes both `ea` and `ptr` equal to the old pointer plus `step`, one clock later.
- R5: In circular mode (`mode` 2), `ea` is the old pointer. Let off = old pointer minus `base`, and s = off plus `step`.
  - If s is at least `len`, the new pointer is `base` + s − `len`.
  - If s is below zero, the new pointer is `base` + s + `len`.
  - Otherwise the new pointer is `base` + s.
- R6: In aligned circular mode (`mode` 3), the buffer start is the old pointer with its low k bits cleared, where 2^k is the smallest power of two not below `len`. The wrap rule of R5 then applies with that start.
- R7: In the two circular modes, a step whose magnitude is at least `len` is refused. `step_err` is 1 and `ea_vld` is 0 one clock later, and `ptr` is unchanged. In the linear modes `step_err` is never set.
- R8: In reverse-carry mode (`mode` 4), `ea` is the old pointer. The low `fft_lg` bits of the pointer receive 2^(fft_lg−1), with the carry moving from the top bit toward bit 0, and the upper bits are kept. `step` has no effect. For `fft_lg` 3, the low bits visit 0,4,2,6,1,5,3,7 and then return to 0. For `fft_lg` 0, the pointer does not move.
- R9: A clock with neither `ld` nor `stp` leaves `ptr` unchanged and drives `ea_vld` and `step_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Addressing mode code (see R3 to R8) |
| step | input | AW | Signed pointer step |
| base | input | AW | Circular buffer start (mode 2) |
| len | input | AW | Circular buffer length (modes 2 and 3) |
| fft_lg | input | LGW | log2 of the FFT size for mode 4 |
| ld | input | 1 | Load the pointer from `ld_val` |
| ld_val | input | AW | Pointer load value |
| stp | input | 1 | Perform one access and update the pointer |
| ea | output | AW | Effective address of the last access |
| ea_vld | output | 1 | `ea` holds an accepted access this cycle |
| ptr | output | AW | Current pointer |
| step_err | output | 1 | Last step was refused (R7) |

## Verification
The bench builds the block with AW = 10, so LGW = 4. With that width, a linear step past 1023 shows the modulo-2^AW wrap of the pointer in a few cycles. A buffer at 200 of length 10 shows both wrap directions and the exact step limit of 10. In aligned circular mode, a length of 12 inside a 16-word region separates the length from the region size. Reverse-carry mode is run with 3 and 4 index bits over a full pass and back to the start, and with 0 bits, where the pointer must stay put.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        M_POST    = 3'd0,
        M_PRE     = 3'd1,
        M_CIRC    = 3'd2,
        M_ALIGN   = 3'd3,
        M_REVC    = 3'd4
    } agu_mode_e;

endpackage

// File: rtl/agu_wrap.sv
module agu_wrap #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] len_i,
    input  logic [AW-1:0] step_i,
    output logic [AW-1:0] nxt_o,
    output logic          bad_o
);
    localparam int EW = AW + 2;

    logic [AW-1:0]        off_u;
    logic signed [EW-1:0] off_s, len_s, stp_s, mag_s, sum_s, adj_s;

    always_comb begin
        off_u = ptr_i - base_i;
        off_s = signed'({2'b00, off_u});
        len_s = signed'({2'b00, len_i});
        stp_s = signed'({{2{step_i[AW-1]}}, step_i});
        mag_s = stp_s[EW-1] ? -stp_s : stp_s;
        bad_o = (mag_s >= len_s);
        sum_s = off_s + stp_s;
        if (sum_s < 0) begin
            adj_s = sum_s + len_s;
        end else if (sum_s >= len_s) begin
            adj_s = sum_s - len_s;
        end else begin
            adj_s = sum_s;
        end
        nxt_o = base_i + adj_s[AW-1:0];
    end

endmodule

// File: rtl/agu_revc.sv
module agu_revc #(
    parameter int AW  = 16,
    parameter int LGW = 5
) (
    input  logic [AW-1:0]  ptr_i,
    input  logic [LGW-1:0] lg_i,
    output logic [AW-1:0]  nxt_o
);
    logic c;

    always_comb begin
        nxt_o = ptr_i;
        c     = 1'b1;
        for (int i = AW - 1; i >= 0; i--) begin
            if (i < int'(lg_i)) begin
                nxt_o[i] = ptr_i[i] ^ c;
                c        = ptr_i[i] & c;
            end
        end
    end

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int AW  = 16,
    parameter int LGW = $clog2(AW + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     mode,
    input  logic [AW-1:0]  step,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  len,
    input  logic [LGW-1:0] fft_lg,
    input  logic           ld,
    input  logic [AW-1:0]  ld_val,
    input  logic           stp,
    output logic [AW-1:0]  ea,
    output logic           ea_vld,
    output logic [AW-1:0]  ptr,
    output logic           step_err
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] ea;
        logic          vld;
        logic          err;
    } st_t;

    st_t st_d, st_q;

    logic [AW-1:0] circ_nxt, al_nxt, rev_nxt, lin_nxt;
    logic [AW-1:0] lm1, al_msk, al_base;
    logic          circ_bad, al_bad;

    // aligned region: smear (len-1) down to get the covering mask
    always_comb begin
        lm1            = len - 1'b1;
        al_msk[AW-1]   = lm1[AW-1];
        for (int i = AW - 2; i >= 0; i--) begin
            al_msk[i] = al_msk[i+1] | lm1[i];
        end
        al_base = st_q.ptr & ~al_msk;
    end

    agu_wrap #(.AW(AW)) u_wrap_circ (
        .ptr_i (st_q.ptr),
        .base_i(base),
        .len_i (len),
        .step_i(step),
        .nxt_o (circ_nxt),
        .bad_o (circ_bad)
    );

    agu_wrap #(.AW(AW)) u_wrap_align (
        .ptr_i (st_q.ptr),
        .base_i(al_base),
        .len_i (len),
        .step_i(step),
        .nxt_o (al_nxt),
        .bad_o (al_bad)
    );

    agu_revc #(.AW(AW), .LGW(LGW)) u_revc (
        .ptr_i(st_q.ptr),
        .lg_i (fft_lg),
        .nxt_o(rev_nxt)
    );

    assign lin_nxt = st_q.ptr + step;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        if (ld) begin
            st_d.ptr = ld_val;
        end else if (stp) begin
            st_d.vld = 1'b1;
            st_d.ea  = st_q.ptr;
            case (mode)
                M_PRE: begin
                    st_d.ptr = lin_nxt;
                    st_d.ea  = lin_nxt;
                end
                M_CIRC: begin
                    if (circ_bad) begin
                        st_d.err = 1'b1;
                        st_d.vld = 1'b0;
                    end else begin
                        st_d.ptr = circ_nxt;
                    end
                end
                M_ALIGN: begin
                    if (al_bad) begin
                        st_d.err = 1'b1;
                        st_d.vld = 1'b0;
                    end else begin
                        st_d.ptr = al_nxt;
                    end
                end
                M_REVC:  st_d.ptr = rev_nxt;
                default: st_d.ptr = lin_nxt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ea       = st_q.ea;
    assign ea_vld   = st_q.vld;
    assign ptr      = st_q.ptr;
    assign step_err = st_q.err;

    // bits above the FFT index field, used by the R8 check
    logic [AW-1:0] hi_msk;
    always_comb begin
        for (int i = 0; i < AW; i++) begin
            hi_msk[i] = (i >= int'(fft_lg));
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (ptr == $past(ld_val)) && !ea_vld);

    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_err |-> $stable(ptr) && !ea_vld);

    p_no_err_lin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stp && !ld && (mode == M_POST || mode == M_PRE)) |=> !step_err);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !stp) |=> $stable(ptr) && !ea_vld && !step_err);

    p_circ_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stp && !ld && mode == M_CIRC && (ptr - base) < len)
        |=> ((ptr - $past(base)) < $past(len)));

    p_revc_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stp && !ld && mode == M_REVC)
        |=> ((ptr & $past(hi_msk)) == ($past(ptr) & $past(hi_msk))) && ea_vld);

    p_post_ea_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stp && !ld && mode == M_POST) |=> (ea == $past(ptr)) && ea_vld);

endmodule

// File: tb/agu_top_tb_top.sv
module agu_top_tb_top;
    localparam int AW  = 10;
    localparam int LGW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     mode = 3'd0;
    logic [AW-1:0]  step = '0;
    logic [AW-1:0]  base = '0;
    logic [AW-1:0]  len = '0;
    logic [LGW-1:0] fft_lg = '0;
    logic           ld = 1'b0;
    logic [AW-1:0]  ld_val = '0;
    logic           stp = 1'b0;
    logic [AW-1:0]  ea;
    logic           ea_vld;
    logic [AW-1:0]  ptr;
    logic           step_err;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    agu_top #(.AW(AW), .LGW(LGW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .step(step), .base(base),
        .len(len), .fft_lg(fft_lg), .ld(ld), .ld_val(ld_val), .stp(stp),
        .ea(ea), .ea_vld(ea_vld), .ptr(ptr), .step_err(step_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(input int v);
        @(negedge clk);
        ld = 1'b1; ld_val = AW'(v);
        @(negedge clk);
        ld = 1'b0;
    endtask

    task automatic do_step(input int s);
        @(negedge clk);
        stp = 1'b1; step = AW'(s);
        @(negedge clk);
        stp = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ptr", int'(ptr), 0);
        chk("R1 ea_vld", int'(ea_vld), 0);
        chk("R1 step_err", int'(step_err), 0);
    endtask

    task automatic t_load();
        load(321);
        chk("R2 ptr after load", int'(ptr), 321);
        chk("R2 ea_vld after load", int'(ea_vld), 0);
        mode = 3'd0;
        @(negedge clk);
        ld = 1'b1; ld_val = AW'(50); stp = 1'b1; step = AW'(7);
        @(negedge clk);
        ld = 1'b0; stp = 1'b0;
        chk("R2 load beats step", int'(ptr), 50);
        chk("R2 no access on load", int'(ea_vld), 0);
    endtask

    task automatic t_post();
        mode = 3'd0;
        load(100);
        do_step(3);
        chk("R3 ea post +3", int'(ea), 100);
        chk("R3 ptr post +3", int'(ptr), 103);
        chk("R3 ea_vld", int'(ea_vld), 1);
        do_step(-5);
        chk("R3 ea post -5", int'(ea), 103);
        chk("R3 ptr post -5", int'(ptr), 98);
        load(1023);
        do_step(2);
        chk("R3 ptr modulo 2^AW", int'(ptr), 1);
        do_step(600);
        chk("R7 no err in linear", int'(step_err), 0);
        mode = 3'd6;
        load(10);
        do_step(4);
        chk("R3 unused code as post ea", int'(ea), 10);
        chk("R3 unused code as post ptr", int'(ptr), 14);
    endtask

    task automatic t_pre();
        mode = 3'd1;
        load(98);
        do_step(2);
        chk("R4 ea pre", int'(ea), 100);
        chk("R4 ptr pre", int'(ptr), 100);
        do_step(-10);
        chk("R4 ea pre neg", int'(ea), 90);
    endtask

    task automatic t_circ();
        mode = 3'd2; base = AW'(200); len = AW'(10);
        load(207);
        do_step(4);
        chk("R5 ea circ", int'(ea), 207);
        chk("R5 wrap past end", int'(ptr), 201);
        do_step(-3);
        chk("R5 wrap below start", int'(ptr), 208);
        do_step(9);
        chk("R5 largest legal step", int'(ptr), 207);
        chk("R7 legal step no err", int'(step_err), 0);
        do_step(10);
        chk("R7 step == len err", int'(step_err), 1);
        chk("R7 refused no ea_vld", int'(ea_vld), 0);
        chk("R7 ptr held", int'(ptr), 207);
        do_step(-10);
        chk("R7 neg step err", int'(step_err), 1);
        chk("R7 ptr held neg", int'(ptr), 207);
    endtask

    task automatic t_align();
        mode = 3'd3; base = AW'(0); len = AW'(12);
        load(291);
        do_step(10);
        chk("R6 aligned wrap up", int'(ptr), 289);
        do_step(-2);
        chk("R6 aligned wrap down", int'(ptr), 299);
        do_step(12);
        chk("R7 aligned err", int'(step_err), 1);
        chk("R7 aligned ptr held", int'(ptr), 299);
    endtask

    function automatic int rev_bits(input int v, input int n);
        int r = 0;
        for (int i = 0; i < n; i++) if (v[i]) r |= (1 << (n - 1 - i));
        return r;
    endfunction

    task automatic t_revc();
        int seq8 [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
        mode = 3'd4; fft_lg = LGW'(3);
        load(64);
        for (int k = 0; k < 8; k++) begin
            do_step(123);
            chk($sformatf("R8 lg3 ea step %0d", k), int'(ea), 64 + seq8[k]);
        end
        chk("R8 lg3 back to start", int'(ptr), 64);
        fft_lg = LGW'(4);
        load(512);
        for (int k = 0; k < 16; k++) begin
            do_step(0);
            chk($sformatf("R8 lg4 ea step %0d", k), int'(ea), 512 + rev_bits(k, 4));
        end
        chk("R8 lg4 back to start", int'(ptr), 512);
        fft_lg = LGW'(0);
        load(77);
        do_step(5);
        chk("R8 lg0 ptr unchanged", int'(ptr), 77);
        chk("R8 lg0 ea", int'(ea), 77);
    endtask

    task automatic t_idle();
        mode = 3'd0;
        load(400);
        step = AW'(9);
        repeat (3) @(negedge clk);
        chk("R9 idle ptr", int'(ptr), 400);
        chk("R9 idle ea_vld", int'(ea_vld), 0);
        chk("R9 idle step_err", int'(step_err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_post();
        t_pre();
        t_circ();
        t_align();
        t_revc();
        t_idle();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule